// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that owns a small bank of 8-bit control registers. Each register's contents drive parallel outputs into the rest of the chip. A host on the two-wire bus reaches the bank with indexed block transfers, and every transfer names a start index and a byte count. A write sends the index, then the count, then the data bytes. A read sends the index in a short write phase. After a repeated START, the target returns a count byte ahead of the data.

Both bus lines are sampled with the fast system clock. Each line passes through a two-flop synchronizer and a three-sample agreement filter. The block then finds the START, repeated START and STOP conditions and the clock edges. It shifts bits in and out and drives SDA as an open-drain pull-down. Some register bits are not host-owned. A revision nibble comes from an input, the vendor nibble is constant, and three frequency-select straps are captured while reset is held. The host can read all of these back but cannot change them.

Top module: `smb_idx_regbank`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits equal 69h (D2h for write, D3h for read). Any other address is left unacknowledged, and the rest of that transfer is ignored.
- R2: A write of START, D2h, index N, count X and X data bytes acknowledges every byte and stores the data in registers N to N+X-1 in order. Registers do not change at any other time.
- R3: Data bytes that arrive after X bytes of a write have been taken are not acknowledged and are discarded.
- R4: A write that targets an index above 9 is acknowledged but has no effect. A read at an index above 9 returns FFh.
- R5: After D2h and index N, a repeated START and D3h make the target send a count byte first. The count is 10-N, or 0 when N is above 9. The target then sends registers N, N+1 and onward, MSB first, for as long as the host acknowledges. A NACK ends the read.
- R6: Reset values for registers 0 to 9 are FFh, FEh, FFh, 00h, 07h, 00h, 18h (bits 7:3), RO, 44h and 1Eh.
- R7: Register 7 is read-only. It reads as {rev_id, 4'b0001}. In register 8, bits 7 and 3 always read 0 and ignore writes.
- R8: Register 6 bits 2:0 read back the fs_strap value captured while rst_n was low. Host writes to those bits are discarded.
- R9: A START or STOP in the middle of a byte abandons the transfer without changing any register.
- R10: A pulse of two system clocks or less on SCL is filtered out and does not count as a bus clock edge.
- R11: sda_oe changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| fs_strap | input | 3 | Frequency-select straps, captured during reset |
| rev_id | input | 4 | Revision nibble shown in register 7 |
| regs_flat | output | NREG*8 | Register view, register i at bits [8i+7:8i] |

## Verification
The bench uses the default build: a 7-bit address of 69h, ten registers, two synchronizer stages and three filter votes. With ten registers, a single index byte reaches past the end of the bank, so discarded writes, FFh reads and the zero count byte are all exercised. The three-vote filter allows a two-clock SCL pulse in the middle of a write bit to test rejection while the stored byte is checked. A behavioural copy of the register bank is compared with regs_flat on every clock whenever no write is in flight. That comparison covers the wrong-address and abort cases as they happen.

// File: rtl/smbreg_pkg.sv
// Shared types and register-map constants for the SMBus indexed register target.
// Assumes registers are 8 bits wide and indexes fit in one byte.
package smbreg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RXB,
        ST_ACK,
        ST_TXB,
        ST_TACK
    } xfer_st_e;

    typedef enum logic [1:0] {
        PH_IDX,
        PH_CNT,
        PH_DAT
    } wr_ph_e;

    // Reset value of each host-owned register.
    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFE;
            2:       return 8'hFF;
            4:       return 8'h07;
            6:       return 8'h18;
            8:       return 8'h44;
            9:       return 8'h1E;
            default: return 8'h00;
        endcase
    endfunction

    // Bits the host may write (1) versus fixed or input-driven bits (0).
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            6:       return 8'hF8;
            7:       return 8'h00;
            8:       return 8'h77;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smbreg_filter.sv
// Line conditioner: a synchronizer chain followed by an agreement filter.
// The output moves only when VOTE_LEN consecutive synchronized samples agree.
// Assumes SYNC_LEN >= 2 and VOTE_LEN >= 2. The idle level of the line is 1.
module smbreg_filter #(
    parameter int SYNC_LEN = 2,
    parameter int VOTE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [SYNC_LEN-1:0] sync_q;
    logic [VOTE_LEN-1:0] hist_q;
    logic                sync_o;

    assign sync_o = sync_q[SYNC_LEN-1];

    // Synchronize the raw line, keep a sample history and update the filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
            hist_q <= {hist_q[VOTE_LEN-2:0], sync_o};
            if (&hist_q) begin
                line_o <= 1'b1;
            end else if (~|hist_q) begin
                line_o <= 1'b0;
            end
        end
    end

    // R10: a filtered change follows a settled synchronized level.
    assert_filter_settled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(sync_o, 2) == line_o));

endmodule

// File: rtl/smbreg_bank.sv
// Register bank: NREG byte registers with per-bit write masks.
// Read-only fields come from the straps (captured in reset) and from rev_id.
// Indexes at or above NREG write nothing and read FFh.
module smbreg_bank
    import smbreg_pkg::*;
#(
    parameter int NREG = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_idx,
    output logic [7:0]      rd_data,
    input  logic [2:0]      fs_strap,
    input  logic [3:0]      rev_id,
    output logic [NREG*8-1:0] regs_flat
);

    localparam logic [7:0] LAST_IDX = 8'(NREG - 1);

    logic [7:0]        q    [NREG];
    logic [7:0]        view [NREG];
    logic [2:0]        strap_q;
    logic [NREG*8-1:0] q_pk;

    // Hold the straps for as long as reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= fs_strap;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] WMASK = reg_wmask(g);
        logic [7:0] ro_val;

        if (g == 6) begin : g_strap
            assign ro_val = {5'b0, strap_q};
        end else if (g == 7) begin : g_ident
            assign ro_val = {rev_id, 4'b0001};
        end else begin : g_plain
            assign ro_val = 8'h00;
        end

        // Store the writable bits of this register on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= reg_reset(g);
            end else if (wr_en && (wr_idx == 8'(g))) begin
                q[g] <= (q[g] & ~WMASK) | (wr_data & WMASK);
            end
        end

        assign view[g]            = (q[g] & WMASK) | (ro_val & ~WMASK);
        assign regs_flat[g*8 +: 8] = view[g];
        assign q_pk[g*8 +: 8]      = q[g];
    end

    // Select the register addressed by the transmitter, FFh beyond the bank.
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == 8'(i)) begin
                rd_data = view[i];
            end
        end
    end

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q_pk));

    assert_oob_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx > LAST_IDX)) |=> $stable(q_pk));

endmodule

// File: rtl/smbreg_xfer.sv
// Bus protocol engine: finds START/STOP and clock edges on the filtered lines,
// matches the address, walks index/count/data for writes and count/data for
// reads, and drives SDA low for acknowledges and zero data bits.
// Assumes each SCL phase lasts several system clocks after filtering.
module smbreg_xfer
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic [7:0] rd_idx,
    input  logic [7:0] rd_data
);

    localparam logic [7:0] NREG_B = 8'(NREG);

    xfer_st_e   st;
    wr_ph_e     ph;
    logic       scl_d, sda_d;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] idx;
    logic [7:0] remain;
    logic       is_rd;
    logic       host_ack;
    logic [7:0] avail;
    logic       start_ev, stop_ev, rise, fall;

    assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
    assign rise     = scl_f & ~scl_d;
    assign fall     = ~scl_f & scl_d;
    assign avail    = (idx < NREG_B) ? (NREG_B - idx) : 8'h00;
    assign rd_idx   = idx;

    // Protocol sequencing, bit shifting and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ph       <= PH_IDX;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
            bitcnt   <= '0;
            shreg    <= '0;
            idx      <= '0;
            remain   <= '0;
            is_rd    <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
            wr_en <= 1'b0;
            if (start_ev) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_RXB: begin
                        if (rise && (bitcnt != 4'd8)) begin
                            shreg  <= {shreg[6:0], sda_f};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (fall && (bitcnt == 4'd8)) begin
                            if (st == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_rd  <= shreg[0];
                                    ph     <= PH_IDX;
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                case (ph)
                                    PH_IDX: begin
                                        idx    <= shreg;
                                        ph     <= PH_CNT;
                                        sda_oe <= 1'b1;
                                        st     <= ST_ACK;
                                    end
                                    PH_CNT: begin
                                        remain <= shreg;
                                        ph     <= PH_DAT;
                                        sda_oe <= 1'b1;
                                        st     <= ST_ACK;
                                    end
                                    default: begin
                                        if (remain != 8'd0) begin
                                            wr_en   <= 1'b1;
                                            wr_idx  <= idx;
                                            wr_data <= shreg;
                                            idx     <= idx + 8'd1;
                                            remain  <= remain - 8'd1;
                                            sda_oe  <= 1'b1;
                                            st      <= ST_ACK;
                                        end else begin
                                            st <= ST_IDLE;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK: begin
                        if (fall) begin
                            bitcnt <= '0;
                            if (is_rd) begin
                                shreg  <= avail;
                                sda_oe <= ~avail[7];
                                st     <= ST_TXB;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RXB;
                            end
                        end
                    end
                    ST_TXB: begin
                        if (fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TACK: begin
                        if (rise) begin
                            host_ack <= ~sda_f;
                        end else if (fall) begin
                            if (host_ack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                                idx    <= idx + 8'd1;
                                bitcnt <= '0;
                                st     <= ST_TXB;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_oe_only_when_engaged_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st != ST_IDLE));

    assert_write_only_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ph == PH_DAT));

    assert_oe_steady_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_f) |-> $stable(sda_oe));

endmodule

// File: rtl/smb_idx_regbank.sv
// Top level: conditions both bus lines, runs the protocol engine and
// holds the register bank whose contents appear on regs_flat.
// Assumes SCL high and low phases each span well over SYNC_LEN+VOTE_LEN clocks.
module smb_idx_regbank #(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 10,
    parameter int         SYNC_LEN = 2,
    parameter int         VOTE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        fs_strap,
    input  logic [3:0]        rev_id,
    output logic [NREG*8-1:0] regs_flat
);

    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines;
    logic [NLINE-1:0] flt_lines;
    logic             wr_en;
    logic [7:0]       wr_idx, wr_data, rd_idx, rd_data;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        smbreg_filter #(
            .SYNC_LEN (SYNC_LEN),
            .VOTE_LEN (VOTE_LEN)
        ) u_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    smbreg_xfer #(
        .DEV_ADDR (DEV_ADDR),
        .NREG     (NREG)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (flt_lines[1]),
        .sda_f   (flt_lines[0]),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    smbreg_bank #(
        .NREG (NREG)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .fs_strap  (fs_strap),
        .rev_id    (rev_id),
        .regs_flat (regs_flat)
    );

endmodule

// File: tb/smb_idx_regbank_tb.sv
// Bench: a bus host made of tasks, plus a behavioural register image that is
// compared with regs_flat on every clock while no write is in flight.
module smb_idx_regbank_tb;

    localparam int Q    = 16;
    localparam int NREG = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [3:0] rev   = 4'h9;
    logic       sda_oe;
    logic [NREG*8-1:0] regs;
    logic       sda_line;

    assign sda_line = sda_h & ~sda_oe;

    smb_idx_regbank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_h),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .fs_strap  (strap),
        .rev_id    (rev),
        .regs_flat (regs)
    );

    int         total = 0;
    int         bad   = 0;
    int         prints = 0;
    int         r11_viol = 0;
    bit         cmp_en = 1'b0;
    logic [7:0] img [NREG];
    logic       prev_scl = 1'b1;
    logic       prev_oe  = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-clock comparison of the image with the register outputs (R2, R9).
    always @(negedge clk) begin
        if (cmp_en) begin
            total++;
            for (int i = 0; i < NREG; i++) begin
                if (regs[i*8 +: 8] != img[i]) begin
                    bad++;
                    if (prints < 8) begin
                        prints++;
                        $display("FAIL R2/R9 image reg%0d actual=%0h expected=%0h",
                                 i, regs[i*8 +: 8], img[i]);
                    end
                    break;
                end
            end
        end
        // R11: drive must not move while SCL stays high.
        if (rst_n && scl_h && prev_scl && (sda_oe != prev_oe)) r11_viol++;
        prev_scl = scl_h;
        prev_oe  = sda_oe;
    end

    task automatic bstart();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic brestart();
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h = b[i];
            if (glitch && i == 3) begin
                tick(Q/2); scl_h = 1'b1; tick(2); scl_h = 1'b0; tick(Q/2 - 2);
            end else begin
                tick(Q);
            end
            scl_h = 1'b1; tick(2*Q);
            scl_h = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        ack = (sda_line == 1'b0);
        tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; tick(Q);
            scl_h = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_h = 1'b0; tick(Q);
        end
        sda_h = ~ack; tick(Q);
        scl_h = 1'b1; tick(2*Q);
        scl_h = 1'b0; tick(Q);
        sda_h = 1'b1;
    endtask

    // Index phase of a read followed by the repeated START and read address.
    task automatic read_open(input logic [7:0] idx);
        bit a;
        bstart();
        send_byte(8'hD2, 1'b0, a); chk("R1 addr D2 ack", a, 1);
        send_byte(idx, 1'b0, a);   chk("R5 index ack", a, 1);
        brestart();
        send_byte(8'hD3, 1'b0, a); chk("R1 addr D3 ack", a, 1);
    endtask

    initial begin
        bit         a;
        logic [7:0] b;

        img = '{8'hFF, 8'hFE, 8'hFF, 8'h00, 8'h07, 8'h00, 8'h1D, 8'h91, 8'h44, 8'h1E};
        tick(10);
        rst_n = 1'b1;
        tick(2);
        strap = 3'b010;
        tick(20);

        // R6, R7, R8: reset view
        for (int i = 0; i < NREG; i++) chk($sformatf("R6 reset reg%0d", i), regs[i*8 +: 8], img[i]);
        chk("R8 strap held", regs[6*8 +: 3], 3'b101);
        chk("R11 idle release", sda_oe, 0);
        cmp_en = 1'b1;

        // R2: block write to 2..4
        cmp_en = 1'b0;
        bstart();
        send_byte(8'hD2, 1'b0, a); chk("R1 write addr ack", a, 1);
        send_byte(8'h02, 1'b0, a); chk("R2 index ack", a, 1);
        send_byte(8'h03, 1'b0, a); chk("R2 count ack", a, 1);
        send_byte(8'hA5, 1'b0, a); chk("R2 data0 ack", a, 1);
        send_byte(8'h3C, 1'b0, a); chk("R2 data1 ack", a, 1);
        send_byte(8'h0F, 1'b0, a); chk("R2 data2 ack", a, 1);
        bstop();
        img[2] = 8'hA5; img[3] = 8'h3C; img[4] = 8'h0F;
        chk("R2 reg3", regs[3*8 +: 8], 8'h3C);
        cmp_en = 1'b1;

        // R5: full read from index 0
        read_open(8'h00);
        recv_byte(1'b1, b); chk("R5 count from 0", b, 10);
        for (int i = 0; i < NREG; i++) begin
            recv_byte(i < NREG - 1, b);
            chk($sformatf("R5 read reg%0d", i), b, img[i]);
        end
        bstop();

        // R7, R8: writes to fixed bits are dropped
        cmp_en = 1'b0;
        bstart();
        send_byte(8'hD2, 1'b0, a); chk("R1 ack", a, 1);
        send_byte(8'h06, 1'b0, a); chk("R8 index ack", a, 1);
        send_byte(8'h02, 1'b0, a); chk("R8 count ack", a, 1);
        send_byte(8'hFF, 1'b0, a); chk("R8 data ack", a, 1);
        send_byte(8'h00, 1'b0, a); chk("R7 data ack", a, 1);
        bstop();
        img[6] = 8'hFD;
        chk("R8 reg6 strap bits kept", regs[6*8 +: 8], 8'hFD);
        chk("R7 reg7 fixed", regs[7*8 +: 8], 8'h91);
        cmp_en = 1'b1;

        // R3, R4: write across the end, then past the count
        cmp_en = 1'b0;
        bstart();
        send_byte(8'hD2, 1'b0, a); chk("R1 ack", a, 1);
        send_byte(8'h08, 1'b0, a); chk("R4 index ack", a, 1);
        send_byte(8'h03, 1'b0, a); chk("R4 count ack", a, 1);
        send_byte(8'hFF, 1'b0, a); chk("R7 reg8 data ack", a, 1);
        send_byte(8'h00, 1'b0, a); chk("R4 reg9 data ack", a, 1);
        send_byte(8'h77, 1'b0, a); chk("R4 index10 data ack", a, 1);
        send_byte(8'h55, 1'b0, a); chk("R3 beyond count nack", a, 0);
        bstop();
        img[8] = 8'h77; img[9] = 8'h00;
        chk("R7 reg8 reserved zero", regs[8*8 +: 8], 8'h77);
        cmp_en = 1'b1;

        // R4, R5: read at the last index and past the end
        read_open(8'h09);
        recv_byte(1'b1, b); chk("R5 count from 9", b, 1);
        recv_byte(1'b1, b); chk("R5 reg9 read", b, 8'h00);
        recv_byte(1'b0, b); chk("R4 read past end", b, 8'hFF);
        bstop();
        read_open(8'h0C);
        recv_byte(1'b1, b); chk("R5 count past end", b, 0);
        recv_byte(1'b0, b); chk("R4 read idx12", b, 8'hFF);
        bstop();

        // R1: foreign address, image compare stays on
        bstart();
        send_byte(8'hD4, 1'b0, a); chk("R1 foreign addr nack", a, 0);
        send_byte(8'h00, 1'b0, a); chk("R1 ignored byte nack", a, 0);
        bstop();

        // R9: STOP and repeated START inside a data byte
        bstart();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_bits(8'h00, 4, 1'b0);
        bstop();
        chk("R9 stop abort reg0", regs[0 +: 8], 8'hFF);
        bstart();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_bits(8'h00, 3, 1'b0);
        brestart();
        bstop();
        chk("R9 restart abort reg1", regs[8 +: 8], 8'hFE);

        // R10: short SCL pulse inside a data bit
        cmp_en = 1'b0;
        bstart();
        send_byte(8'hD2, 1'b0, a);
        send_byte(8'h05, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        send_byte(8'h5A, 1'b1, a); chk("R10 glitched byte ack", a, 1);
        bstop();
        img[5] = 8'h5A;
        chk("R10 reg5 value", regs[5*8 +: 8], 8'h5A);
        cmp_en = 1'b1;
        tick(20);

        chk("R11 drive steady with SCL high", r11_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule